// File: doc/BRIEF.md
# D-PHY Lane Timing Calculator

This block turns a serial lane rate, given in Mbps, into the set of high-speed and low-power timing counts that one lane of a D-PHY transmitter needs. The lane is named by a clock-lane flag and a data-lane index, and a variant select chooses between two rate-band tables. The result is a group of packed count fields together with the base address of that lane's register window, ready for a configuration sequencer to write out.

Some counts come from arithmetic on the byte clock (rate·10^6/8) or the escape clock, which is the byte clock divided down to at most 20 MHz. Other counts are taken from a rate-band table that holds separate zero-time values for clock and data lanes. One shared sequential divider does all of the work. A request is accepted over a valid/ready handshake. The block raises `in_ready` only when it is idle, so a requester stalls for as long as `in_ready` is low. The result side has no back-pressure: `out_valid` stays high and the fields hold their values until the next request is accepted.

Top module: `dphy_lane_timing`

## Requirements
- R1: A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low from the edge after acceptance until the result is ready. `out_valid` is low in that same window, and then stays high with every field held unchanged until the next acceptance. Input changes that are not accepted have no effect.
- R2: After reset, `in_ready` is 1, `out_valid` is 0 and every output field is 0.
- R3: `out_base` is 0x100 for the clock lane (`in_clk_lane`=1). For data lane n (`in_data_idx`=n, `in_clk_lane`=0) it is 0x180 + n·0x80.
- R4: `out_hs_exit` = ceil(120·rate/8000), saturated to 31.
- R5: With UI = floor((1000 + floor(rate/2)) / rate): `out_clk_post` = ceil((70+52·UI)·rate/8000) and `out_clk_pre` = ceil(8·UI·rate/8000), each saturated to 15. Both are 0 for a data lane.
- R6: Let L = ceil(60·rate/8000). `out_lpx` is L−2 when L>2, otherwise L, saturated to 63.
- R7: With D = ceil(rate/160) and E = floor(rate·125000/D): `out_ta_go`, `out_ta_sure` and `out_ta_wait` are ceil(T·E/10^9) for T = 240, 120 and 300, each saturated to 63.
- R8: `out_wake_hi` is 3 and `out_wake_lo` is 0xFF in every result.
- R9: The band is the first table entry, in ascending order of limit, whose limit is at least the rate; the last entry is used when the rate exceeds every limit. Variant 0 limits are 110,150,200,250,300,400,500,600,700,800,1000. Variant 1 adds 1400,1600,1800,2000. The entry gives `out_hs_prepare`, `out_hs_trail`, and a zero count that is taken from the clock-lane column or the data-lane column depending on the lane type. For example, variant 0 at 110 Mbps gives prepare 0x20, trail 0x22, zero 0x16 for the clock lane and 0x02 for a data lane.
- R10: Any value larger than its field saturates to the field maximum instead of wrapping; this includes a table zero value of 0x7A, which becomes 63.
- R11: A rate of 0 is treated as a rate of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Block idle, request can be taken |
| in_rate | input | 12 | Lane rate in Mbps |
| in_clk_lane | input | 1 | 1 selects the clock lane |
| in_data_idx | input | 2 | Data lane index when not the clock lane |
| in_variant | input | 1 | Band table select |
| out_valid | output | 1 | Result fields valid and held |
| out_base | output | 10 | Lane register window base |
| out_lpx | output | 6 | LP transmit time count |
| out_hs_prepare | output | 7 | HS prepare count |
| out_hs_zero | output | 6 | HS zero count |
| out_hs_trail | output | 7 | HS trail count |
| out_hs_exit | output | 5 | HS exit count |
| out_clk_post | output | 4 | Clock post count (clock lane) |
| out_clk_pre | output | 4 | Clock pre count (clock lane) |
| out_wake_hi | output | 2 | Wakeup count high part |
| out_wake_lo | output | 8 | Wakeup count low part |
| out_ta_go | output | 6 | Turnaround go count |
| out_ta_sure | output | 6 | Turnaround sure count |
| out_ta_wait | output | 6 | Turnaround wait count |

## Verification
Every band limit of both tables is tried at the limit and one above it. This separates a less-than from a less-or-equal search and catches an off-by-one entry. Rates past the top limit check the fallback to the last entry. A coarse sweep over the full rate range, with lane types and variants rotated, exercises the ceiling rounding, the saturation of exit, post and zero counts at high rates, and the escape divider steps at multiples of 160. The rates 0, 266 and 267 separate the rate clamp and the two sides of the lpx correction. Requests held during a busy computation, and inputs changed after a result, show whether non-accepted inputs leak into the fields.

// File: rtl/dphy_tc_pkg.sv
`timescale 1ns/1ps
package dphy_tc_pkg;
  typedef struct packed {
    logic [11:0] max_rate;
    logic [7:0]  prep;
    logic [7:0]  zero_clk;
    logic [7:0]  zero_dat;
    logic [7:0]  trail;
  } band_t;

  localparam int BANDS_A   = 11;
  localparam int BANDS_B   = 15;
  localparam int BANDS_MAX = 15;

  function automatic band_t band_a(input int i);
    band_t b;
    case (i)
      0:  b = '{12'd110,  8'h20, 8'h16, 8'h02, 8'h22};
      1:  b = '{12'd150,  8'h06, 8'h16, 8'h03, 8'h45};
      2:  b = '{12'd200,  8'h18, 8'h17, 8'h04, 8'h0b};
      3:  b = '{12'd250,  8'h05, 8'h17, 8'h05, 8'h16};
      4:  b = '{12'd300,  8'h51, 8'h18, 8'h06, 8'h2c};
      5:  b = '{12'd400,  8'h64, 8'h19, 8'h07, 8'h33};
      6:  b = '{12'd500,  8'h20, 8'h1b, 8'h07, 8'h4e};
      7:  b = '{12'd600,  8'h6a, 8'h1d, 8'h08, 8'h3a};
      8:  b = '{12'd700,  8'h3e, 8'h1e, 8'h08, 8'h6a};
      9:  b = '{12'd800,  8'h21, 8'h1f, 8'h09, 8'h29};
      default: b = '{12'd1000, 8'h09, 8'h20, 8'h09, 8'h27};
    endcase
    return b;
  endfunction

  function automatic band_t band_b(input int i);
    band_t b;
    case (i)
      0:  b = '{12'd110,  8'h7f, 8'h16, 8'h02, 8'h02};
      1:  b = '{12'd150,  8'h7f, 8'h16, 8'h03, 8'h02};
      2:  b = '{12'd200,  8'h7f, 8'h17, 8'h04, 8'h02};
      3:  b = '{12'd250,  8'h7f, 8'h17, 8'h05, 8'h04};
      4:  b = '{12'd300,  8'h7f, 8'h18, 8'h06, 8'h04};
      5:  b = '{12'd400,  8'h7e, 8'h19, 8'h07, 8'h04};
      6:  b = '{12'd500,  8'h7c, 8'h1b, 8'h07, 8'h08};
      7:  b = '{12'd600,  8'h70, 8'h1d, 8'h08, 8'h10};
      8:  b = '{12'd700,  8'h40, 8'h1e, 8'h08, 8'h30};
      9:  b = '{12'd800,  8'h02, 8'h1f, 8'h09, 8'h30};
      10: b = '{12'd1000, 8'h08, 8'h20, 8'h09, 8'h30};
      11: b = '{12'd1400, 8'h03, 8'h32, 8'h14, 8'h0f};
      12: b = '{12'd1600, 8'h42, 8'h36, 8'h0e, 8'h0f};
      13: b = '{12'd1800, 8'h47, 8'h7a, 8'h0e, 8'h0f};
      default: b = '{12'd2000, 8'h64, 8'h7a, 8'h0e, 8'h0b};
    endcase
    return b;
  endfunction

  function automatic logic [7:0] sat_field(input logic [39:0] v, input int w);
    logic [39:0] lim;
    lim = (40'd1 << w) - 40'd1;
    return (v > lim) ? lim[7:0] : v[7:0];
  endfunction
endpackage

// File: rtl/dphy_tc_div.sv
`timescale 1ns/1ps
module dphy_tc_div #(
  parameter int NUM_W = 40,
  parameter int DEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] n_q, q_q;
  logic [DEN_W-1:0] d_q, r_q;
  logic [DEN_W:0]   trial, diff;
  logic             ge, run_q, done_q;
  logic [CNT_W-1:0] cnt_q;

  assign trial = {r_q, n_q[NUM_W-1]};
  assign ge    = trial >= {1'b0, d_q};
  assign diff  = trial - {1'b0, d_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q <= '0; q_q <= '0; d_q <= '0; r_q <= '0;
      cnt_q <= '0; run_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        n_q   <= num;
        d_q   <= den;
        r_q   <= '0;
        q_q   <= '0;
        cnt_q <= CNT_W'(NUM_W);
        run_q <= 1'b1;
      end else if (run_q) begin
        n_q   <= n_q << 1;
        r_q   <= ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        q_q   <= {q_q[NUM_W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done = done_q;
  assign quo  = q_q;
endmodule

// File: rtl/dphy_tc_band.sv
`timescale 1ns/1ps
module dphy_tc_band
  import dphy_tc_pkg::*;
#(
  parameter int RATE_W = 12
) (
  input  logic [RATE_W-1:0] rate,
  input  logic              variant,
  output band_t             sel
);
  always_comb begin
    int    n;
    band_t e;
    n   = variant ? BANDS_B : BANDS_A;
    sel = variant ? band_b(BANDS_B - 1) : band_a(BANDS_A - 1);
    for (int i = BANDS_MAX - 1; i >= 0; i--) begin
      e = variant ? band_b(i) : band_a(i);
      if (i < n && int'(rate) <= int'(e.max_rate)) sel = e;
    end
  end
endmodule

// File: rtl/dphy_lane_timing.sv
`timescale 1ns/1ps
module dphy_lane_timing
  import dphy_tc_pkg::*;
#(
  parameter int RATE_W = 12,
  parameter int NUM_W  = 40,
  parameter int DEN_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [RATE_W-1:0] in_rate,
  input  logic              in_clk_lane,
  input  logic [1:0]        in_data_idx,
  input  logic              in_variant,
  output logic              out_valid,
  output logic [9:0]        out_base,
  output logic [5:0]        out_lpx,
  output logic [6:0]        out_hs_prepare,
  output logic [5:0]        out_hs_zero,
  output logic [6:0]        out_hs_trail,
  output logic [4:0]        out_hs_exit,
  output logic [3:0]        out_clk_post,
  output logic [3:0]        out_clk_pre,
  output logic [1:0]        out_wake_hi,
  output logic [7:0]        out_wake_lo,
  output logic [5:0]        out_ta_go,
  output logic [5:0]        out_ta_sure,
  output logic [5:0]        out_ta_wait
);
  localparam int STEPS  = 10;
  localparam int STEP_W = $clog2(STEPS);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

  logic              busy_q, ovalid_q, go_q;
  logic [STEP_W-1:0] step_q;
  logic [RATE_W-1:0] rate_q;
  logic              clk_lane_q, var_q;
  logic [1:0]        idx_q;
  logic [DEN_W-1:0]  escdiv_q, ui_q, esc_q;
  logic [NUM_W-1:0]  num, quo, r_n, ui_n, esc_n, lpx_adj;
  logic [DEN_W-1:0]  den;
  logic              div_done;
  band_t             band;

  assign r_n   = NUM_W'(rate_q);
  assign ui_n  = NUM_W'(ui_q);
  assign esc_n = NUM_W'(esc_q);

  always_comb begin
    num = '0;
    den = DEN_W'(8000);
    case (step_q)
      STEP_W'(0): begin num = r_n + NUM_W'(159); den = DEN_W'(160); end
      STEP_W'(1): begin num = NUM_W'(1000) + (r_n >> 1); den = DEN_W'(rate_q); end
      STEP_W'(2): begin num = r_n * NUM_W'(125000); den = escdiv_q; end
      STEP_W'(3): num = NUM_W'(120) * r_n + NUM_W'(7999);
      STEP_W'(4): num = (NUM_W'(70) + NUM_W'(52) * ui_n) * r_n + NUM_W'(7999);
      STEP_W'(5): num = NUM_W'(8) * ui_n * r_n + NUM_W'(7999);
      STEP_W'(6): num = NUM_W'(60) * r_n + NUM_W'(7999);
      STEP_W'(7): begin num = NUM_W'(240) * esc_n + NUM_W'(999999999); den = DEN_W'(1000000000); end
      STEP_W'(8): begin num = NUM_W'(120) * esc_n + NUM_W'(999999999); den = DEN_W'(1000000000); end
      default:    begin num = NUM_W'(300) * esc_n + NUM_W'(999999999); den = DEN_W'(1000000000); end
    endcase
  end

  assign lpx_adj = (quo > NUM_W'(2)) ? quo - NUM_W'(2) : quo;

  dphy_tc_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) i_div (
    .clk(clk), .rst_n(rst_n), .start(go_q), .num(num), .den(den),
    .done(div_done), .quo(quo)
  );

  dphy_tc_band #(.RATE_W(RATE_W)) i_band (
    .rate(rate_q), .variant(var_q), .sel(band)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; ovalid_q <= 1'b0; go_q <= 1'b0; step_q <= '0;
      rate_q <= '0; clk_lane_q <= 1'b0; var_q <= 1'b0; idx_q <= '0;
      escdiv_q <= '0; ui_q <= '0; esc_q <= '0;
      out_base <= '0; out_lpx <= '0; out_hs_prepare <= '0; out_hs_zero <= '0;
      out_hs_trail <= '0; out_hs_exit <= '0; out_clk_post <= '0; out_clk_pre <= '0;
      out_wake_hi <= '0; out_wake_lo <= '0;
      out_ta_go <= '0; out_ta_sure <= '0; out_ta_wait <= '0;
    end else begin
      go_q <= 1'b0;
      if (in_valid && !busy_q) begin
        rate_q     <= (in_rate == '0) ? RATE_W'(1) : in_rate;
        clk_lane_q <= in_clk_lane;
        idx_q      <= in_data_idx;
        var_q      <= in_variant;
        busy_q     <= 1'b1;
        ovalid_q   <= 1'b0;
        step_q     <= '0;
        go_q       <= 1'b1;
      end else if (busy_q && div_done) begin
        case (step_q)
          STEP_W'(0): escdiv_q <= quo[DEN_W-1:0];
          STEP_W'(1): ui_q     <= quo[DEN_W-1:0];
          STEP_W'(2): esc_q    <= quo[DEN_W-1:0];
          STEP_W'(3): out_hs_exit  <= 5'(sat_field(quo, 5));
          STEP_W'(4): out_clk_post <= clk_lane_q ? 4'(sat_field(quo, 4)) : 4'd0;
          STEP_W'(5): out_clk_pre  <= clk_lane_q ? 4'(sat_field(quo, 4)) : 4'd0;
          STEP_W'(6): out_lpx      <= 6'(sat_field(lpx_adj, 6));
          STEP_W'(7): out_ta_go    <= 6'(sat_field(quo, 6));
          STEP_W'(8): out_ta_sure  <= 6'(sat_field(quo, 6));
          default:    out_ta_wait  <= 6'(sat_field(quo, 6));
        endcase
        if (step_q == LAST) begin
          busy_q         <= 1'b0;
          ovalid_q       <= 1'b1;
          out_base       <= clk_lane_q ? 10'h100 : 10'h180 + {1'b0, idx_q, 7'b0};
          out_hs_prepare <= 7'(sat_field(40'(band.prep), 7));
          out_hs_trail   <= 7'(sat_field(40'(band.trail), 7));
          out_hs_zero    <= 6'(sat_field(40'(clk_lane_q ? band.zero_clk : band.zero_dat), 6));
          out_wake_hi    <= 2'd3;
          out_wake_lo    <= 8'hFF;
        end else begin
          step_q <= step_q + 1'b1;
          go_q   <= 1'b1;
        end
      end
    end
  end

  assign in_ready  = !busy_q;
  assign out_valid = ovalid_q;
endmodule

// File: rtl/dphy_lane_timing_chk.sv
`timescale 1ns/1ps
module dphy_lane_timing_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic [9:0] out_base,
  input logic [5:0] out_lpx,
  input logic [6:0] out_hs_prepare,
  input logic [5:0] out_hs_zero,
  input logic [6:0] out_hs_trail,
  input logic [4:0] out_hs_exit,
  input logic [3:0] out_clk_post,
  input logic [3:0] out_clk_pre,
  input logic [1:0] out_wake_hi,
  input logic [7:0] out_wake_lo,
  input logic [5:0] out_ta_go,
  input logic [5:0] out_ta_sure,
  input logic [5:0] out_ta_wait
);
  logic [78:0] fields;
  assign fields = {out_base, out_lpx, out_hs_prepare, out_hs_zero, out_hs_trail,
                   out_hs_exit, out_clk_post, out_clk_pre, out_wake_hi, out_wake_lo,
                   out_ta_go, out_ta_sure, out_ta_wait};

  AST_VALID_IMPLIES_READY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready); // R1
  AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!out_valid && !in_ready)); // R1
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !in_valid) |=> (out_valid && $stable(fields))); // R1
  AST_WAKE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_wake_hi == 2'd3 && out_wake_lo == 8'hFF)); // R8
  AST_DATA_NO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_base != 10'h100) |-> (out_clk_post == 4'd0 && out_clk_pre == 4'd0)); // R5
  AST_BASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_base == 10'h100 || out_base == 10'h180 || out_base == 10'h200 ||
                   out_base == 10'h280 || out_base == 10'h300)); // R3
endmodule

bind dphy_lane_timing dphy_lane_timing_chk i_chk (.*);

// File: tb/test_dphy_lane_timing.sv
`timescale 1ns/1ps
module test_dphy_lane_timing;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_clk_lane = 1'b0, in_variant = 1'b0, out_valid;
  logic [11:0] in_rate = '0;
  logic [1:0]  in_data_idx = '0;
  logic [9:0]  out_base;
  logic [5:0]  out_lpx, out_hs_zero, out_ta_go, out_ta_sure, out_ta_wait;
  logic [6:0]  out_hs_prepare, out_hs_trail;
  logic [4:0]  out_hs_exit;
  logic [3:0]  out_clk_post, out_clk_pre;
  logic [1:0]  out_wake_hi;
  logic [7:0]  out_wake_lo;

  int checks = 0, failures = 0, reqs = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dphy_lane_timing i_dphy_lane_timing (.*);

  int lim_a[11]  = '{110,150,200,250,300,400,500,600,700,800,1000};
  int prep_a[11] = '{'h20,'h06,'h18,'h05,'h51,'h64,'h20,'h6a,'h3e,'h21,'h09};
  int zc_a[11]   = '{'h16,'h16,'h17,'h17,'h18,'h19,'h1b,'h1d,'h1e,'h1f,'h20};
  int zd_a[11]   = '{'h02,'h03,'h04,'h05,'h06,'h07,'h07,'h08,'h08,'h09,'h09};
  int tr_a[11]   = '{'h22,'h45,'h0b,'h16,'h2c,'h33,'h4e,'h3a,'h6a,'h29,'h27};
  int lim_b[15]  = '{110,150,200,250,300,400,500,600,700,800,1000,1400,1600,1800,2000};
  int prep_b[15] = '{'h7f,'h7f,'h7f,'h7f,'h7f,'h7e,'h7c,'h70,'h40,'h02,'h08,'h03,'h42,'h47,'h64};
  int zc_b[15]   = '{'h16,'h16,'h17,'h17,'h18,'h19,'h1b,'h1d,'h1e,'h1f,'h20,'h32,'h36,'h7a,'h7a};
  int zd_b[15]   = '{'h02,'h03,'h04,'h05,'h06,'h07,'h07,'h08,'h08,'h09,'h09,'h14,'h0e,'h0e,'h0e};
  int tr_b[15]   = '{'h02,'h02,'h02,'h04,'h04,'h04,'h08,'h10,'h30,'h30,'h30,'h0f,'h0f,'h0f,'h0b};

  function automatic longint sat(input longint v, input longint mx);
    return (v > mx) ? mx : v;
  endfunction

  task automatic chk(input string req, input string name, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, name, act, exp);
    end
  endtask

  task automatic check_result(input int rate, input bit cl, input int idx, input bit v);
    longint r, d, ui, e, lraw;
    int b, n;
    r  = (rate == 0) ? 1 : rate;                       // R11
    d  = (r + 159) / 160;
    ui = (1000 + r / 2) / r;
    e  = (r * 125000) / d;
    n  = v ? 15 : 11;
    b  = n - 1;
    for (int i = n - 1; i >= 0; i--) if (r <= (v ? lim_b[i] : lim_a[i])) b = i;
    lraw = (60 * r + 7999) / 8000;
    if (lraw > 2) lraw = lraw - 2;
    chk("R1",  "out_valid", out_valid, 1);
    chk("R3",  "base", out_base, cl ? 'h100 : 'h180 + idx * 'h80);
    chk("R4",  "hs_exit", out_hs_exit, sat((120 * r + 7999) / 8000, 31));
    chk("R5",  "clk_post", out_clk_post, cl ? sat(((70 + 52 * ui) * r + 7999) / 8000, 15) : 0);
    chk("R5",  "clk_pre", out_clk_pre, cl ? sat((8 * ui * r + 7999) / 8000, 15) : 0);
    chk("R6",  "lpx", out_lpx, sat(lraw, 63));
    chk("R7",  "ta_go", out_ta_go, sat((240 * e + 999999999) / 1000000000, 63));
    chk("R7",  "ta_sure", out_ta_sure, sat((120 * e + 999999999) / 1000000000, 63));
    chk("R7",  "ta_wait", out_ta_wait, sat((300 * e + 999999999) / 1000000000, 63));
    chk("R8",  "wake_hi", out_wake_hi, 3);
    chk("R8",  "wake_lo", out_wake_lo, 'hFF);
    chk("R9",  "hs_prepare", out_hs_prepare, v ? prep_b[b] : prep_a[b]);
    chk("R9",  "hs_trail", out_hs_trail, v ? tr_b[b] : tr_a[b]);
    chk("R10", "hs_zero", out_hs_zero,
        sat(cl ? (v ? zc_b[b] : zc_a[b]) : (v ? zd_b[b] : zd_a[b]), 63));
  endtask

  task automatic run_req(input int rate, input bit cl, input int idx, input bit v, input bit noise);
    int wd;
    @(negedge clk);
    in_valid = 1'b1; in_rate = 12'(rate); in_clk_lane = cl;
    in_data_idx = 2'(idx); in_variant = v;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    chk("R1", "in_ready_busy", in_ready, 0);
    chk("R1", "out_valid_busy", out_valid, 0);
    if (noise) begin
      in_rate = ~12'(rate); in_clk_lane = ~cl; in_data_idx = ~2'(idx); in_variant = ~v;
    end else in_valid = 1'b0;
    wd = 0;
    while (!out_valid && wd < 2000) begin @(negedge clk); wd++; end
    in_valid = 1'b0;
    if (wd >= 2000) chk("R1", "watchdog_result", 0, 1);
    check_result(rate, cl, idx, v);
    if (noise) begin
      in_rate = 12'hABC; in_clk_lane = ~in_clk_lane; in_variant = ~in_variant;
      repeat (4) @(negedge clk);
      check_result(rate, cl, idx, v);  // R1: non-accepted inputs leave the result alone
    end
    reqs++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R2", "in_ready_rst", in_ready, 1);
    chk("R2", "out_valid_rst", out_valid, 0);
    chk("R2", "fields_rst", {out_base, out_lpx, out_hs_prepare, out_hs_zero, out_hs_trail,
        out_hs_exit, out_clk_post, out_clk_pre, out_wake_hi, out_wake_lo,
        out_ta_go, out_ta_sure, out_ta_wait} == '0, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2", "in_ready_after", in_ready, 1);
    // R11 and R6 corner rates
    run_req(0, 1'b1, 0, 1'b0, 1'b0);
    run_req(266, 1'b1, 0, 1'b0, 1'b0);
    run_req(267, 1'b0, 2, 1'b1, 1'b1);
    run_req(4095, 1'b1, 0, 1'b1, 1'b0);
    run_req(4095, 1'b0, 3, 1'b0, 1'b1);
    // R9 band boundaries for both variants, lanes rotated (R3)
    for (int v = 0; v < 2; v++)
      for (int i = 0; i < (v ? 15 : 11); i++)
        for (int k = 0; k < 2; k++) begin
          int lane;
          lane = (i * 2 + k + v) % 5;
          run_req((v ? lim_b[i] : lim_a[i]) + k, lane == 4, lane, v[0], (i % 4) == 1);
        end
    // R10 clock-lane zero saturation in variant 1
    run_req(1700, 1'b1, 0, 1'b1, 1'b0);
    run_req(3000, 1'b1, 0, 1'b1, 1'b0);
    // R4 R5 R7 coarse sweep
    for (int rt = 3; rt < 4096; rt += 53) begin
      int lane;
      lane = (rt / 53) % 5;
      run_req(rt, lane == 4, lane, rt[1], 1'b0);
    end
    for (int rt = 159; rt <= 161; rt++) run_req(rt, 1'b0, 1, 1'b0, 1'b0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", reqs, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule